// File: doc/BRIEF.md
# Edge-Cleared Watchdog Timer

This block watches a single input that software toggles while it is healthy. Every change of level, whether upward or downward, restarts an internal cycle counter. If the counter reaches the configured timeout with no change seen, the active-low watchdog output drops and stays down. It recovers when software toggles the input again or when the manual reset input is pulled low. A system that wants a reset on timeout routes this output into its reset generator's manual reset input. The output then drops, a reset follows, and that reset returns the output high.

The timer does not run while the system reset input is asserted, and it starts from zero when that reset is released. A supply-good flag overrides the watchdog state: while the supply is bad the output is low. When the supply recovers the output goes high on the next clock, with no recovery interval. An enable input switches the whole function off. While it is off the timer is held at zero and the output is high.

The control is a five-state machine. OFF is the disabled state. LOWV is the supply-bad state. HOLD is the frozen state while system reset is asserted. RUN is the counting state. TRIPPED is the latched timeout state. The transitions are checked in priority order. Enable low sends any state to OFF. Otherwise a bad supply sends any state to LOWV. OFF and LOWV leave for HOLD or RUN, depending on the system reset. RUN goes to HOLD on system reset and to TRIPPED on timeout. HOLD goes to RUN when the system reset is released. TRIPPED leaves for HOLD or RUN on an input edge or when the manual reset is low. The output is low exactly in TRIPPED and LOWV.

Top module: `wdt_guard`

## Requirements
- R1: After RUN is entered with the counter at zero and with no input edge, the output is still high after TWD_CYCLES clock edges and is low after TWD_CYCLES+1 edges. Here the count starts at the edge that enters RUN.
- R2: A rising change and a falling change of `wdt_in` both clear the timer. The change reaches the control logic at the third rising clock edge after the input changes, through a two-flop synchronizer and a compare with the previous value. An edge seen in TRIPPED returns the output high at that clock edge.
- R3: While `sys_rst` is high, the counter is held at zero and no timeout can occur. After `sys_rst` falls, counting starts at once, so R1's timing applies from the first clock edge after the release.
- R4: In TRIPPED, the output stays low for any number of cycles until an input edge arrives or `man_rst_n` is sampled low. This holds also while `sys_rst` is high. When `man_rst_n` is sampled low, the output is high after that clock edge.
- R5: When `enable` is high and `supply_ok` is sampled low, the output is low after that clock edge, whether or not a timeout occurred.
- R6: When `supply_ok` returns high, the output is high after the next clock edge, and the timer restarts from zero.
- R7: While `enable` is low, the output is high after each clock edge and the counter is held at zero. This holds even when the supply is bad. Input edges seen while disabled have no effect on later timing.
- R8: An input edge that reaches the control logic in the same cycle as the timeout takes priority. The output stays high and a fresh full period starts.
- R9: While `rst_n` is low, the block is in OFF and the output is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset of this block |
| wdt_in | input | 1 | Software-toggled service input, asynchronous |
| sys_rst | input | 1 | High while the system reset is asserted |
| supply_ok | input | 1 | High while the supply is above its threshold |
| man_rst_n | input | 1 | Active-low manual reset; clears a latched timeout |
| enable | input | 1 | High enables the watchdog function |
| wdt_out_n | output | 1 | Active-low watchdog output |

## Verification
The hardest case to reach from the ports is R8, where a service edge has to arrive in exactly the cycle the counter hits its last value. The stimulus first services a timeout, which gives a known clock edge where RUN starts from zero. It then schedules the next toggle three clocks earlier than the timeout edge, to allow for the synchronizer latency. Another toggle one clock too late would be counted as a latched timeout. A mutant that lets the timeout win is caught when the output is checked at the edge where the timeout would have landed.

// File: rtl/wdt_pkg.sv
package wdt_pkg;

    typedef enum logic [2:0] {
        ST_OFF     = 3'd0,
        ST_HOLD    = 3'd1,
        ST_RUN     = 3'd2,
        ST_TRIPPED = 3'd3,
        ST_LOWV    = 3'd4
    } wdt_state_e;

endpackage

// File: rtl/wdt_in_sync.sv
module wdt_in_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic async_in,
    output logic level,
    output logic toggled
);
    localparam int LAST = STAGES - 1;

    logic [LAST:0] chain_q;
    logic          prev_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q[0] <= 1'b0;
        else        chain_q[0] <= async_in;
    end

    generate
        for (genvar i = 1; i < STAGES; i++) begin : g_stage
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) chain_q[i] <= 1'b0;
                else        chain_q[i] <= chain_q[i-1];
            end
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) prev_q <= 1'b0;
        else        prev_q <= chain_q[LAST];
    end

    assign level   = chain_q[LAST];
    assign toggled = chain_q[LAST] ^ prev_q;
endmodule

// File: rtl/wdt_timer.sv
module wdt_timer #(
    parameter int TWD_CYCLES = 80_000_000
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          run,
    input  logic                          clr,
    output logic                          expired,
    output logic [$clog2(TWD_CYCLES)-1:0] count
);
    localparam int            CW       = $clog2(TWD_CYCLES);
    localparam logic [CW-1:0] LAST_VAL = CW'(TWD_CYCLES - 1);

    logic [CW-1:0] cnt_q;
    logic          at_limit;

    // the edge clear wins over the limit in the same cycle
    assign at_limit = (cnt_q == LAST_VAL);
    assign expired  = run && !clr && at_limit;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                  cnt_q <= '0;
        else if (!run || clr || expired) cnt_q <= '0;
        else                         cnt_q <= cnt_q + CW'(1);
    end

    assign count = cnt_q;
endmodule

// File: rtl/wdt_fsm.sv
module wdt_fsm
    import wdt_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       enable,
    input  logic       supply_ok,
    input  logic       sys_rst,
    input  logic       man_rst_n,
    input  logic       edge_seen,
    input  logic       expired,
    output wdt_state_e state,
    output logic       out_n
);
    wdt_state_e state_q;
    wdt_state_e state_d;

    always_comb begin
        state_d = state_q;
        if (!enable) begin
            state_d = ST_OFF;
        end else if (!supply_ok) begin
            state_d = ST_LOWV;
        end else begin
            unique case (state_q)
                ST_OFF, ST_LOWV: state_d = sys_rst ? ST_HOLD : ST_RUN;
                ST_HOLD: begin
                    if (!sys_rst) state_d = ST_RUN;
                end
                ST_RUN: begin
                    if (sys_rst)      state_d = ST_HOLD;
                    else if (expired) state_d = ST_TRIPPED;
                end
                ST_TRIPPED: begin
                    if (edge_seen || !man_rst_n)
                        state_d = sys_rst ? ST_HOLD : ST_RUN;
                end
                default: state_d = ST_OFF;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_OFF;
        else        state_q <= state_d;
    end

    always_comb begin
        out_n = !((state_q == ST_TRIPPED) || (state_q == ST_LOWV));
    end

    assign state = state_q;
endmodule

// File: rtl/wdt_guard.sv
module wdt_guard
    import wdt_pkg::*;
#(
    parameter int TWD_CYCLES  = 80_000_000,
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic wdt_in,
    input  logic sys_rst,
    input  logic supply_ok,
    input  logic man_rst_n,
    input  logic enable,
    output logic wdt_out_n
);
    localparam int CW = $clog2(TWD_CYCLES);

    wdt_state_e    state_q;
    logic          edge_seen;
    logic          in_level;
    logic          timer_run;
    logic          expired;
    logic [CW-1:0] cnt_q;

    wdt_in_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in (wdt_in),
        .level    (in_level),
        .toggled  (edge_seen)
    );

    assign timer_run = (state_q == ST_RUN) && enable && supply_ok && !sys_rst;

    wdt_timer #(.TWD_CYCLES(TWD_CYCLES)) u_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .run     (timer_run),
        .clr     (edge_seen),
        .expired (expired),
        .count   (cnt_q)
    );

    wdt_fsm u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .enable    (enable),
        .supply_ok (supply_ok),
        .sys_rst   (sys_rst),
        .man_rst_n (man_rst_n),
        .edge_seen (edge_seen),
        .expired   (expired),
        .state     (state_q),
        .out_n     (wdt_out_n)
    );

    logic unused_level;
    assign unused_level = in_level;
endmodule

// File: rtl/wdt_guard_chk.sv
module wdt_guard_chk
    import wdt_pkg::*;
#(
    parameter int CW = 8
) (
    input logic          clk,
    input logic          rst_n,
    input logic          sys_rst,
    input logic          supply_ok,
    input logic          man_rst_n,
    input logic          enable,
    input logic          wdt_out_n,
    input logic          edge_seen,
    input wdt_state_e    state_q,
    input logic [CW-1:0] cnt_q
);
    a_r5_low_supply_drops: assert property (@(posedge clk) disable iff (!rst_n)
        (enable && !supply_ok) |=> !wdt_out_n);

    a_r6_supply_back_high: assert property (@(posedge clk) disable iff (!rst_n)
        (enable && $rose(supply_ok)) |=> wdt_out_n);

    a_r7_disabled_high: assert property (@(posedge clk) disable iff (!rst_n)
        !enable |=> wdt_out_n);

    a_r7_off_cleared: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_OFF) |-> (cnt_q == '0));

    a_r3_hold_cleared: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_HOLD) |-> (cnt_q == '0));

    a_r3_no_trip_in_reset: assert property (@(posedge clk) disable iff (!rst_n)
        (sys_rst && enable && supply_ok && wdt_out_n) |=> wdt_out_n);

    a_r4_latched_low: assert property (@(posedge clk) disable iff (!rst_n)
        ((state_q == ST_TRIPPED) && enable && supply_ok && man_rst_n && !edge_seen)
            |=> !wdt_out_n);

    a_r8_edge_wins: assert property (@(posedge clk) disable iff (!rst_n)
        (edge_seen && enable && supply_ok) |=> wdt_out_n);
endmodule

bind wdt_guard wdt_guard_chk #(.CW($clog2(TWD_CYCLES))) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .sys_rst   (sys_rst),
    .supply_ok (supply_ok),
    .man_rst_n (man_rst_n),
    .enable    (enable),
    .wdt_out_n (wdt_out_n),
    .edge_seen (edge_seen),
    .state_q   (state_q),
    .cnt_q     (cnt_q)
);

// File: tb/sim_wdt_guard.sv
module sim_wdt_guard;
    localparam int TWD = 20;
    localparam int NV  = 38;

    // row: [13:6] clocks, [5] wdt_in, [4] enable, [3] supply_ok,
    //      [2] sys_rst, [1] man_rst_n, [0] expected wdt_out_n
    localparam logic [13:0] VEC [NV] = '{
        {8'd20, 6'b011011}, {8'd1, 6'b011010}, {8'd30, 6'b011010},   // R1 R1 R4
        {8'd2,  6'b111010}, {8'd1, 6'b111011},                       // R2 rising
        {8'd19, 6'b111011}, {8'd1, 6'b111010},                       // R1
        {8'd3,  6'b011011},                                          // R2 falling
        {8'd17, 6'b011011}, {8'd3, 6'b111011},                       // R8
        {8'd19, 6'b111011}, {8'd1, 6'b111010},                       // R8
        {8'd1,  6'b111001},                                          // R4 manual
        {8'd40, 6'b111111}, {8'd20, 6'b111011}, {8'd1, 6'b111010},   // R3
        {8'd1,  6'b110010}, {8'd1, 6'b111011},                       // R5 R6
        {8'd1,  6'b110010}, {8'd50, 6'b110010},                      // R5
        {8'd1,  6'b111011}, {8'd19, 6'b111011}, {8'd1, 6'b111010},   // R6
        {8'd1,  6'b101011}, {8'd60, 6'b101011}, {8'd5, 6'b001011},   // R7
        {8'd20, 6'b011011}, {8'd1, 6'b011010}, {8'd2, 6'b000011},    // R7
        {8'd2,  6'b010010}, {8'd1, 6'b011011},                       // R5 R6
        {8'd19, 6'b011011}, {8'd1, 6'b011010},                       // R1
        {8'd10, 6'b011110}, {8'd1, 6'b011101},                       // R4 in reset
        {8'd30, 6'b011111}, {8'd20, 6'b011011}, {8'd1, 6'b011010}    // R3
    };

    logic clk = 1'b0;
    logic rst_n, wdt_in, sys_rst, supply_ok, man_rst_n, enable;
    logic wdt_out_n;
    int   checks = 0;
    int   errors = 0;
    bit   done   = 1'b0;

    always #10 clk = ~clk;

    wdt_guard #(.TWD_CYCLES(TWD)) u0 (
        .clk       (clk),
        .rst_n     (rst_n),
        .wdt_in    (wdt_in),
        .sys_rst   (sys_rst),
        .supply_ok (supply_ok),
        .man_rst_n (man_rst_n),
        .enable    (enable),
        .wdt_out_n (wdt_out_n)
    );

    function automatic string tag_of(int i);
        case (i)
            0, 1, 5, 6, 31, 32:  return "R1";
            3, 4, 7:             return "R2";
            13, 14, 15, 35, 36, 37: return "R3";
            2, 12, 33, 34:       return "R4";
            16, 18, 19, 29:      return "R5";
            17, 20, 21, 22, 30:  return "R6";
            23, 24, 25, 26, 27, 28: return "R7";
            default:             return "R8";
        endcase
    endfunction

    task automatic check(input string req, input logic exp);
        checks++;
        if (wdt_out_n !== exp) begin
            errors++;
            $display("FAIL %s: wdt_out_n actual %b expected %b at %0t",
                     req, wdt_out_n, exp, $time);
        end
    endtask

    initial begin
        rst_n = 1'b0; wdt_in = 1'b0; sys_rst = 1'b0;
        supply_ok = 1'b1; man_rst_n = 1'b1; enable = 1'b1;
        repeat (3) @(negedge clk);
        check("R9", 1'b1);                      // R9 reset state
        rst_n = 1'b1;
        for (int i = 0; i < NV; i++) begin
            wdt_in    = VEC[i][5];
            enable    = VEC[i][4];
            supply_ok = VEC[i][3];
            sys_rst   = VEC[i][2];
            man_rst_n = VEC[i][1];
            repeat (int'(VEC[i][13:6])) @(negedge clk);
            check(tag_of(i), VEC[i][0]);
        end
        // R9: block reset taken mid-trip returns the output high
        rst_n = 1'b0;
        @(negedge clk);
        check("R9", 1'b1);
        rst_n = 1'b1;
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule